// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block sits beside a 32-bit core. It multiplies two signed operands and keeps a running signed 64-bit sum in an accumulator. The accumulator is held as a high word and a low word, and the core can read both words and overwrite either one. An operation is either accumulate (add the full-width product), subtract (take the product away), or drain. Drain returns a 32-bit window of the accumulator, taken from bit 28 upward, and clears the whole accumulator in the same cycle. Every operation is accepted and takes effect at a single clock edge, so the core can issue operations back to back with no interlock.

Operations arrive on a valid/ready port, and drain results leave on a valid/ready port. A drain result is registered. It appears in the cycle after the drain is accepted and stays valid until the consumer takes it. While a result waits with `res_ready` low, `op_ready` is low and no operation of any kind is accepted. With `res_ready` held high, `op_ready` stays high and each result is valid for exactly one cycle. The word-write port is plain control with no handshake. It is never stalled and it overrides any operation in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: While and after reset, `acc_hi`, `acc_lo` and `res_valid` are 0 and `op_ready` is 1.
- R2: An accepted operation with `op_code` 2'b00 adds the signed 64-bit product of `op_a` and `op_b` to the accumulator {acc_hi, acc_lo}, wrapping modulo 2^64. The new value is visible after that edge.
- R3: An accepted operation with `op_code` 2'b01 subtracts the same signed product from the accumulator, wrapping modulo 2^64.
- R4: An accepted operation with `op_code` 2'b10 sets both accumulator words to 0. In the next cycle it raises `res_valid`, with `res_data` equal to bits [59:28] of the accumulator value before the edge. These are the low 32 bits of the accumulator arithmetic-shifted right by 28.
- R5: An accepted operation with `op_code` 2'b11 leaves the accumulator unchanged and produces no result.
- R6: `wr_en[0]` loads `wr_data` into `acc_lo` and `wr_en[1]` loads it into `acc_hi`, at the same edge. A word whose enable is low keeps its value.
- R7: When any `wr_en` bit is high, an operation accepted in the same cycle has no effect on the accumulator. A drain in that cycle still returns the window of the pre-edge accumulator.
- R8: `op_ready` is 1 whenever `res_valid` is 0 or `res_ready` is 1. Operations are accepted on consecutive cycles, and each one builds on the result of the one before.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_data` holds and `op_ready` is 0. An operation offered then has no effect on the accumulator.
- R10: After a result is taken (`res_ready` high) and no new drain is accepted, `res_valid` falls at that edge.
- R11: With `op_valid` low and no write, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The unit can accept an operation |
| op_code | input | 2 | 00 accumulate, 01 subtract, 10 drain, 11 no effect |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| wr_en | input | 2 | Word write enables: bit 0 low word, bit 1 high word |
| wr_data | input | 32 | Value for word writes |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |
| res_valid | output | 1 | A drain result is present |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 32 | Drain result window |

## Verification
The bench builds the unit with its default parameters: 32-bit operands, a 64-bit accumulator and a drain window starting at bit 28. At these values the most-negative-squared product (2^62) and full 64-bit wraparound can be reached with a few operations. Word writes can place bits on both sides of the window edge, so the bits that cross from the high word into the result are checked directly. Random back-pressure on the result port exercises stalls in the middle of accumulate and subtract runs.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ACC   = 2'b00,
    OP_SUB   = 2'b01,
    OP_DRAIN = 2'b10,
    OP_NONE  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          mul_a,
  input  logic [DATA_W-1:0]          mul_b,
  output logic signed [2*DATA_W-1:0] mul_p
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] ext_a;
  logic signed [PROD_W-1:0] ext_b;

  // Sign-extend both operands to full width so the product is exact.
  always_comb begin
    ext_a = PROD_W'($signed(mul_a));
    ext_b = PROD_W'($signed(mul_b));
    mul_p = ext_a * ext_b;
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  mac_op_e                op,
  input  logic [2*DATA_W-1:0]    prod,
  input  logic [1:0]             wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [2*DATA_W-1:0]    acc_q
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALVES = ACC_W / DATA_W;

  logic [ACC_W-1:0] op_next;
  logic             wr_any;

  assign wr_any = |wr_en;

  always_comb begin
    op_next = acc_q;
    if (fire) begin
      unique case (op)
        OP_ACC:   op_next = acc_q + prod;
        OP_SUB:   op_next = acc_q - prod;
        OP_DRAIN: op_next = '0;
        default:  op_next = acc_q;
      endcase
    end
  end

  // One register per word; a write to any word overrides the operation.
  for (genvar h = 0; h < HALVES; h++) begin : g_word
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      if (wr_any)
        word_d = wr_en[h] ? wr_data : word_q;
      else
        word_d = op_next[h*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign acc_q[h*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/mac_result.sv
module mac_result #(
  parameter int DATA_W   = 32,
  parameter int RD_SHIFT = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [2*DATA_W-1:0] acc_q,
  input  logic                res_ready,
  output logic                res_valid,
  output logic [DATA_W-1:0]   res_data,
  output logic                accept_ok
);
  logic [DATA_W-1:0] window;

  assign window    = acc_q[RD_SHIFT +: DATA_W];
  assign accept_ok = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_data  <= window;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RD_SHIFT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  localparam int ACC_W = 2 * DATA_W;

  mac_op_e                  op;
  logic                     fire;
  logic signed [ACC_W-1:0]  prod;
  logic [ACC_W-1:0]         acc_q;

  assign op   = mac_op_e'(op_code);
  assign fire = op_valid && op_ready;

  mac_mult #(.DATA_W(DATA_W)) u_mult (
    .mul_a (op_a),
    .mul_b (op_b),
    .mul_p (prod)
  );

  mac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .op      (op),
    .prod    (prod),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .acc_q   (acc_q)
  );

  mac_result #(.DATA_W(DATA_W), .RD_SHIFT(RD_SHIFT)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (fire && (op == OP_DRAIN)),
    .acc_q     (acc_q),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .accept_ok (op_ready)
  );

  assign acc_hi = acc_q[ACC_W-1:DATA_W];
  assign acc_lo = acc_q[DATA_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int RD_SHIFT = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_code,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] acc_hi,
  input logic [DATA_W-1:0] acc_lo,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);
  localparam int ACC_W = 2 * DATA_W;

  logic                    seen;
  logic                    go;
  logic [ACC_W-1:0]        acc;
  logic signed [ACC_W-1:0] sa;
  logic signed [ACC_W-1:0] sb;
  logic [ACC_W-1:0]        prod_c;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    acc    = {acc_hi, acc_lo};
    go     = op_valid && op_ready && (wr_en == 2'b00);
    sa     = ACC_W'($signed(op_a));
    sb     = ACC_W'($signed(op_b));
    prod_c = sa * sb;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc == '0) && !res_valid);

  assert_acc_add_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    go && (op_code == 2'b00) |=> acc == $past(acc) + $past(prod_c));

  assert_acc_sub_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    go && (op_code == 2'b01) |=> acc == $past(acc) - $past(prod_c));

  assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    go && (op_code == 2'b10) |=> (acc == '0) && res_valid &&
      (res_data == $past(acc[RD_SHIFT +: DATA_W])));

  assert_noop_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    go && (op_code == 2'b11) |=> $stable(acc));

  assert_write_hi_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    wr_en[1] |=> acc_hi == $past(wr_data));

  assert_write_lo_R6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    wr_en[0] |=> acc_lo == $past(wr_data));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (wr_en == 2'b10) |=> $stable(acc_lo));

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || res_ready) |-> op_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !op_ready);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    res_valid && res_ready && !(op_valid && op_code == 2'b10) |=> !res_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !op_valid && (wr_en == 2'b00) |=> $stable(acc));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .RD_SHIFT(RD_SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_code   (op_code),
  .op_a      (op_a),
  .op_b      (op_b),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .acc_hi    (acc_hi),
  .acc_lo    (acc_lo),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_code;
  logic [31:0] op_a, op_b;
  logic [1:0]  wr_en;
  logic [31:0] wr_data;
  logic [31:0] acc_hi, acc_lo;
  logic        res_valid;
  logic        res_ready;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [63:0] m_acc;
  logic        m_rv;
  logic [31:0] m_rd;

  always #4 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .wr_en(wr_en),
    .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [63:0] smul(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    sa = 64'($signed(a));
    sb = 64'($signed(b));
    return sa * sb;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle just after a rising edge, then compare just after the next one.
  task automatic step(input string req, input logic v, input logic [1:0] code,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] we, input logic [31:0] wd, input logic rr);
    logic        rdy, fire;
    logic [63:0] nxt;
    op_valid = v; op_code = code; op_a = a; op_b = b;
    wr_en = we; wr_data = wd; res_ready = rr;
    #1;
    rdy = !m_rv || rr;
    check((m_rv && !rr) ? "R9" : "R8", "op_ready", 64'(op_ready), 64'(rdy));
    fire = v && rdy;
    nxt  = m_acc;
    if (fire) begin
      case (code)
        2'b00: nxt = m_acc + smul(a, b);
        2'b01: nxt = m_acc - smul(a, b);
        2'b10: nxt = 64'd0;
        default: nxt = m_acc;
      endcase
    end
    if (we != 2'b00) begin
      nxt = m_acc;
      if (we[0]) nxt[31:0]  = wd;
      if (we[1]) nxt[63:32] = wd;
    end
    if (fire && code == 2'b10) begin
      m_rv = 1'b1;
      m_rd = m_acc[59:28];
    end else if (rr) begin
      m_rv = 1'b0;
    end
    m_acc = nxt;
    @(posedge clk);
    #1;
    check(req, "acc", {acc_hi, acc_lo}, m_acc);
    check(req, "res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv) check(req, "res_data", 64'(res_data), 64'(m_rd));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00; op_a = '0; op_b = '0;
    wr_en = 2'b00; wr_data = '0; res_ready = 1'b1;
    m_acc = '0; m_rv = 1'b0; m_rd = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "acc in reset", {acc_hi, acc_lo}, 64'd0);
    check("R1", "res_valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    check("R1", "op_ready after reset", 64'(op_ready), 64'd1);

    // Directed corner cases.
    step("R2", 1, 2'b00, 32'h8000_0000, 32'h8000_0000, 2'b00, 0, 1); // +2^62
    step("R2", 1, 2'b00, 32'h8000_0000, 32'h8000_0000, 2'b00, 0, 1); // +2^62 again
    step("R3", 1, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b00, 0, 1); // minus negative
    step("R11", 0, 2'b00, 32'd5, 32'd5, 2'b00, 0, 1);
    step("R4", 1, 2'b10, 0, 0, 2'b00, 0, 1);
    step("R10", 0, 2'b00, 0, 0, 2'b00, 0, 1);
    step("R3", 1, 2'b01, 32'd3, 32'd7, 2'b00, 0, 1);                 // negative acc
    step("R4", 1, 2'b10, 0, 0, 2'b00, 0, 1);
    step("R6", 0, 2'b00, 0, 0, 2'b10, 32'h0ABC_DEF1, 1);
    step("R6", 0, 2'b00, 0, 0, 2'b01, 32'h9000_0000, 1);
    step("R7", 1, 2'b00, 32'd100, 32'd100, 2'b01, 32'h1234_5678, 1);
    step("R7", 1, 2'b10, 0, 0, 2'b10, 32'hFFFF_FFFF, 1);             // drain + write
    step("R5", 1, 2'b11, 32'd9, 32'd9, 2'b00, 0, 1);
    step("R4", 1, 2'b10, 0, 0, 2'b00, 0, 0);                          // result stalls
    step("R9", 1, 2'b00, 32'd11, 32'd13, 2'b00, 0, 0);                // refused
    step("R9", 1, 2'b10, 0, 0, 2'b00, 0, 0);
    step("R10", 0, 2'b00, 0, 0, 2'b00, 0, 1);
    step("R8", 1, 2'b00, 32'd2, 32'd3, 2'b00, 0, 1);                  // back to back
    step("R8", 1, 2'b00, 32'hFFFF_FFFE, 32'd5, 2'b00, 0, 1);
    step("R8", 1, 2'b01, 32'd4, 32'd4, 2'b00, 0, 1);

    // Constrained random mix.
    for (int i = 0; i < 600; i++) begin
      logic        v, rr;
      logic [1:0]  code, we;
      logic [31:0] a, b, wd;
      string       tag;
      v    = ($urandom % 8) != 0;
      rr   = ($urandom % 4) != 0;
      code = 2'($urandom % 4);
      we   = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'b00;
      a    = $urandom; b = $urandom; wd = $urandom;
      if (($urandom % 6) == 0) a = 32'h8000_0000;
      if (we != 2'b00)          tag = "R7";
      else if (!v)              tag = "R11";
      else if (code == 2'b00)   tag = "R2";
      else if (code == 2'b01)   tag = "R3";
      else if (code == 2'b10)   tag = "R4";
      else                      tag = "R5";
      step(tag, v, code, a, b, we, wd, rr);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule